// File: doc/BRIEF.md
# Text Display Raster Timing Generator

This block derives all line and field timing needed to paint a 40-column by 25-row character screen from a 13.875 MHz master clock. It counts clocks within each 64 µs line (888 clocks) and lines within each field. From these counts it produces a composite text sync, a horizontal text window, a vertical text window, a strobe that marks the start of every character cell, the index of the current cell, and a field parity output.

A two-bit mode input selects the field structure. The first three codes run the block from its own counters: two equal half-line fields with interlace, alternating short and long fields, or two equal whole-line fields. The fourth code makes the block follow an external line-flyback input and an external field-flyback input. Each rising edge of those inputs realigns the counters. A separate control input holds the parity output low for displays that do not need it.

The 40 character cells share a 555-clock window, so each cell is 13.875 clocks wide. A fractional accumulator places the strobes so that the cells differ in width by at most one clock. A downstream character generator latches a new code on each strobe.

Top module: `txt_raster_gen`

## Requirements
- R1: After reset the line position and the line count are 0 and the field is the first field. At that point `tsync` is 1, and `hact`, `vact`, `chr_stb`, `chr_col` and `odd_even` are 0.
- R2: A line lasts LINE_CLKS clocks (888). On lines outside the vertical sync group, `tsync` is 1 for line positions 0 to SYNC_END-1 (0..64) and 0 for the rest of the line.
- R3: On the first VS_LINES lines of every field, `tsync` is a broad pulse. It is 1 for line positions below LINE_CLKS/2 - SYNC_END (379) and 0 for the rest of the line.
- R4: `hact` is 1 exactly for line positions ACT_START (231) up to and including ACT_END-1 (785).
- R5: `vact` is 1 exactly on field lines VACT_FIRST to VACT_LAST inclusive. Lines are counted from 0 at the start of each field. The defaults are 41 and 290.
- R6: While `hact` and `vact` are both 1, let t be the line position minus ACT_START and let W be ACT_END-ACT_START. `chr_stb` is 1 when (t·CHARS) mod W < CHARS, which gives CHARS strobes per line. `chr_col` equals floor(t·CHARS / W). Outside the text area both outputs are 0.
- R7: In mode 2'b00 each field is FIELD_LINES + 0.5 lines long. The first field ends after the first half of line FIELD_LINES. The second field begins at line position LINE_CLKS/2 of its line 0 and ends at the end of its line FIELD_LINES.
- R8: In mode 2'b01 the first field has FIELD_LINES lines and the second has FIELD_LINES+1 lines. Both fields start at line position 0.
- R9: In mode 2'b10 both fields have FIELD_LINES whole lines.
- R10: `odd_even` is 1 during the second field and 0 during the first. It changes only at field boundaries. While `even_off` is 1, `odd_even` is 0.
- R11: In mode 2'b11 a rising edge on `lfb` sets the line position to 0 on the next clock and advances the line count by one. Without an edge, lines wrap after LINE_CLKS clocks as usual.
- R12: In mode 2'b11 a rising edge on `ffb` sets the line count to 0 and switches to the other field on the next clock. Without an edge the field does not change, and the line count stops at FIELD_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.875 MHz master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Field structure: 00 interlaced, 01 alternating, 10 equal, 11 external |
| even_off | input | 1 | Forces `odd_even` low |
| lfb | input | 1 | External line flyback (used in mode 11) |
| ffb | input | 1 | External field flyback (used in mode 11) |
| tsync | output | 1 | Composite text sync, active high |
| hact | output | 1 | Horizontal text window |
| vact | output | 1 | Vertical text window |
| chr_stb | output | 1 | Start of a character cell |
| chr_col | output | 6 | Index of the current character cell |
| odd_even | output | 1 | Field parity |

## Verification
Each of the three free-running modes runs for more than a full frame. Every output is compared on every clock against a closed-form position computed from the clock count since reset. This separates the half-line start of the interlaced second field from the 312/313 and 312/312 structures, because the line and position at which each field boundary falls differ between those modes. In external mode, a flyback pulse arrives in the middle of a line and a field pulse follows later. The bench confirms that the sync, window and strobe pattern restarts from the edge and not from the free-running count, and that the line count stops at its limit when no field pulse arrives. Forcing `even_off` during the second field shows that the parity output drops even though the field has not changed.

// File: rtl/txt_raster_pkg.sv
package txt_raster_pkg;

  typedef enum logic [1:0] {
    RM_ILACE = 2'b00,
    RM_ALT   = 2'b01,
    RM_FIX   = 2'b10,
    RM_EXT   = 2'b11
  } rmode_e;

  // index of the last line of the current field
  function automatic int fld_last_line(rmode_e m, logic fld, int lines);
    case (m)
      RM_ILACE: return lines;
      RM_ALT:   return fld ? lines : lines - 1;
      default:  return lines - 1;
    endcase
  endfunction

  // line position of the last clock of the current field
  function automatic int fld_end_h(rmode_e m, logic fld, int lclk);
    return (m == RM_ILACE && !fld) ? (lclk / 2) - 1 : lclk - 1;
  endfunction

  // line position at which the next field starts
  function automatic int fld_start_h(rmode_e m, logic nxt_fld, int lclk);
    return (m == RM_ILACE && nxt_fld) ? lclk / 2 : 0;
  endfunction

endpackage

// File: rtl/txt_raster_hcnt.sv
module txt_raster_hcnt #(
  parameter int LINE_CLKS = 888,
  parameter int SYNC_END  = 65,
  parameter int ACT_START = 231,
  parameter int ACT_END   = 786,
  parameter int HW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lfb_rise,
  input  logic          field_end,
  input  logic [HW-1:0] restart_h,
  output logic [HW-1:0] h,
  output logic [HW-1:0] h_nxt,
  output logic          line_wrap,
  output logic          hact,
  output logic          nsync,
  output logic          bsync
);
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_SYNC  = HW'(SYNC_END);
  localparam logic [HW-1:0] H_BSYNC = HW'(LINE_CLKS / 2 - SYNC_END);
  localparam logic [HW-1:0] H_ACTS  = HW'(ACT_START);
  localparam logic [HW-1:0] H_ACTE  = HW'(ACT_END);

  logic [HW-1:0] h_q;

  assign line_wrap = (h_q == H_LAST);

  always_comb begin
    if (lfb_rise)       h_nxt = '0;
    else if (field_end) h_nxt = restart_h;
    else if (line_wrap) h_nxt = '0;
    else                h_nxt = h_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= '0;
    else        h_q <= h_nxt;
  end

  assign h     = h_q;
  assign hact  = (h_q >= H_ACTS) && (h_q < H_ACTE);
  assign nsync = (h_q < H_SYNC);
  assign bsync = (h_q < H_BSYNC);

endmodule

// File: rtl/txt_raster_vcnt.sv
module txt_raster_vcnt
  import txt_raster_pkg::*;
#(
  parameter int LINE_CLKS   = 888,
  parameter int FIELD_LINES = 312,
  parameter int VS_LINES    = 3,
  parameter int VACT_FIRST  = 41,
  parameter int VACT_LAST   = 290,
  parameter int HW          = 10,
  parameter int LW          = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rmode_e        mode,
  input  logic [HW-1:0] h,
  input  logic          line_wrap,
  input  logic          lfb_rise,
  input  logic          ffb_rise,
  output logic [LW-1:0] line,
  output logic          field,
  output logic          field_end,
  output logic [HW-1:0] restart_h,
  output logic          vsync_line,
  output logic          vact
);
  localparam logic [LW-1:0] L_MAX = LW'(FIELD_LINES);
  localparam logic [LW-1:0] L_VS  = LW'(VS_LINES);
  localparam logic [LW-1:0] L_VF  = LW'(VACT_FIRST);
  localparam logic [LW-1:0] L_VL  = LW'(VACT_LAST);

  logic [LW-1:0] line_q, line_n, last_l;
  logic [HW-1:0] end_h;
  logic          field_q, field_n;

  assign last_l    = LW'(fld_last_line(mode, field_q, FIELD_LINES));
  assign end_h     = HW'(fld_end_h(mode, field_q, LINE_CLKS));
  assign restart_h = HW'(fld_start_h(mode, ~field_q, LINE_CLKS));
  assign field_end = (mode != RM_EXT) && (line_q == last_l) && (h == end_h);

  always_comb begin
    line_n  = line_q;
    field_n = field_q;
    if (mode == RM_EXT) begin
      if (ffb_rise) begin
        line_n  = '0;
        field_n = ~field_q;
      end else if ((lfb_rise || line_wrap) && line_q != L_MAX) begin
        line_n = line_q + 1'b1;
      end
    end else if (field_end) begin
      line_n  = '0;
      field_n = ~field_q;
    end else if (line_wrap) begin
      line_n = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      field_q <= 1'b0;
    end else begin
      line_q  <= line_n;
      field_q <= field_n;
    end
  end

  assign line       = line_q;
  assign field      = field_q;
  assign vsync_line = (line_q < L_VS);
  assign vact       = (line_q >= L_VF) && (line_q <= L_VL);

endmodule

// File: rtl/txt_raster_chr.sv
module txt_raster_chr #(
  parameter int ACT_START = 231,
  parameter int ACT_END   = 786,
  parameter int CHARS     = 40,
  parameter int HW        = 10,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_nxt,
  input  logic          hact,
  input  logic          vact,
  output logic          chr_stb,
  output logic [CW-1:0] chr_col
);
  localparam int            WIN   = ACT_END - ACT_START;
  localparam int            AW    = $clog2(WIN + CHARS + 1);
  localparam int            KW    = $clog2(CHARS + 1);
  localparam logic [AW-1:0] A_WIN = AW'(WIN);
  localparam logic [AW-1:0] A_INC = AW'(CHARS);
  localparam logic [HW-1:0] H_ACTS = HW'(ACT_START);

  logic [AW-1:0] acc_q, acc_sum, acc_n;
  logic [KW-1:0] col_q, col_n;
  logic          wrap, at_start;

  assign acc_sum  = acc_q + A_INC;
  assign wrap     = (acc_sum >= A_WIN);
  assign at_start = (h_nxt == H_ACTS);

  always_comb begin
    if (at_start) begin
      acc_n = '0;
      col_n = '0;
    end else if (hact) begin
      acc_n = wrap ? acc_sum - A_WIN : acc_sum;
      col_n = wrap ? col_q + 1'b1 : col_q;
    end else begin
      acc_n = acc_q;
      col_n = col_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      col_q <= '0;
    end else begin
      acc_q <= acc_n;
      col_q <= col_n;
    end
  end

  assign chr_stb = hact && vact && (acc_q < A_INC);
  assign chr_col = (hact && vact) ? CW'(col_q) : '0;

endmodule

// File: rtl/txt_raster_gen.sv
module txt_raster_gen
  import txt_raster_pkg::*;
#(
  parameter int LINE_CLKS   = 888,
  parameter int SYNC_END    = 65,
  parameter int ACT_START   = 231,
  parameter int ACT_END     = 786,
  parameter int CHARS       = 40,
  parameter int FIELD_LINES = 312,
  parameter int VS_LINES    = 3,
  parameter int VACT_FIRST  = 41,
  parameter int VACT_LAST   = 290,
  parameter int CW          = $clog2(CHARS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          even_off,
  input  logic          lfb,
  input  logic          ffb,
  output logic          tsync,
  output logic          hact,
  output logic          vact,
  output logic          chr_stb,
  output logic [CW-1:0] chr_col,
  output logic          odd_even
);
  localparam int HW = $clog2(LINE_CLKS);
  localparam int LW = $clog2(FIELD_LINES + 1);

  rmode_e        mode_e;
  logic          lfb_q, ffb_q, lfb_rise, ffb_rise;
  logic [HW-1:0] h_cnt, h_nxt, restart_h;
  logic [LW-1:0] line_cnt;
  logic          field_q, field_end, line_wrap;
  logic          nsync, bsync, vsync_line;

  assign mode_e   = rmode_e'(mode);
  assign lfb_rise = (mode_e == RM_EXT) && lfb && !lfb_q;
  assign ffb_rise = (mode_e == RM_EXT) && ffb && !ffb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfb_q <= 1'b0;
      ffb_q <= 1'b0;
    end else begin
      lfb_q <= lfb;
      ffb_q <= ffb;
    end
  end

  txt_raster_hcnt #(
    .LINE_CLKS(LINE_CLKS), .SYNC_END(SYNC_END),
    .ACT_START(ACT_START), .ACT_END(ACT_END), .HW(HW)
  ) u_hcnt (
    .clk(clk), .rst_n(rst_n), .lfb_rise(lfb_rise), .field_end(field_end),
    .restart_h(restart_h), .h(h_cnt), .h_nxt(h_nxt), .line_wrap(line_wrap),
    .hact(hact), .nsync(nsync), .bsync(bsync)
  );

  txt_raster_vcnt #(
    .LINE_CLKS(LINE_CLKS), .FIELD_LINES(FIELD_LINES), .VS_LINES(VS_LINES),
    .VACT_FIRST(VACT_FIRST), .VACT_LAST(VACT_LAST), .HW(HW), .LW(LW)
  ) u_vcnt (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .h(h_cnt), .line_wrap(line_wrap),
    .lfb_rise(lfb_rise), .ffb_rise(ffb_rise), .line(line_cnt), .field(field_q),
    .field_end(field_end), .restart_h(restart_h), .vsync_line(vsync_line),
    .vact(vact)
  );

  txt_raster_chr #(
    .ACT_START(ACT_START), .ACT_END(ACT_END), .CHARS(CHARS), .HW(HW), .CW(CW)
  ) u_chr (
    .clk(clk), .rst_n(rst_n), .h_nxt(h_nxt), .hact(hact), .vact(vact),
    .chr_stb(chr_stb), .chr_col(chr_col)
  );

  assign tsync    = vsync_line ? bsync : nsync;
  assign odd_even = field_q && !even_off;

endmodule

// File: rtl/txt_raster_chk.sv
module txt_raster_chk #(
  parameter int SYNC_END = 65,
  parameter int CHARS    = 40,
  parameter int HW       = 10,
  parameter int LW       = 9,
  parameter int CW       = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          even_off,
  input logic [HW-1:0] h_cnt,
  input logic [LW-1:0] line_cnt,
  input logic          field_q,
  input logic          field_end,
  input logic          line_wrap,
  input logic          lfb_rise,
  input logic          ffb_rise,
  input logic          tsync,
  input logic          hact,
  input logic          vact,
  input logic          chr_stb,
  input logic [CW-1:0] chr_col,
  input logic          odd_even
);
  localparam logic [HW-1:0] H_SYNC = HW'(SYNC_END);
  localparam logic [CW:0]   C_NUM  = (CW+1)'(CHARS);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap && !lfb_rise && !field_end |=> h_cnt == '0); // R2
  AST_BROAD_OUTSIDE_TEXT: assert property (@(posedge clk) disable iff (!rst_n)
    tsync && (h_cnt >= H_SYNC) |-> !vact); // R3
  AST_STB_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    chr_stb |-> hact && vact); // R6
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, chr_col} < C_NUM); // R6
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> field_q != $past(field_q)); // R7
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end && !ffb_rise |=> field_q == $past(field_q)); // R10
  AST_PARITY_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    even_off |-> !odd_even); // R10
  AST_LFB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    lfb_rise |=> h_cnt == '0); // R11
  AST_FFB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ffb_rise |=> line_cnt == '0 && field_q != $past(field_q)); // R12

endmodule

bind txt_raster_gen txt_raster_chk #(
  .SYNC_END(SYNC_END), .CHARS(CHARS), .HW(HW), .LW(LW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .even_off(even_off), .h_cnt(h_cnt),
  .line_cnt(line_cnt), .field_q(field_q), .field_end(field_end),
  .line_wrap(line_wrap), .lfb_rise(lfb_rise), .ffb_rise(ffb_rise),
  .tsync(tsync), .hact(hact), .vact(vact), .chr_stb(chr_stb),
  .chr_col(chr_col), .odd_even(odd_even)
);

// File: tb/txt_raster_gen_bench.sv
module txt_raster_gen_bench;
  localparam int LC = 888, SE = 65, AS = 231, AE = 786, NC = 40;
  localparam int FL = 12, VS = 2, VF = 3, VL = 8;
  localparam int HALF = LC / 2;
  localparam int W = AE - AS;

  logic       clk = 1'b0, rst_n = 1'b0, even_off = 1'b0, lfb = 1'b0, ffb = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tsync, hact, vact, chr_stb, odd_even;
  logic [5:0] chr_col;
  int n_chk = 0, n_bad = 0;

  txt_raster_gen #(
    .LINE_CLKS(LC), .SYNC_END(SE), .ACT_START(AS), .ACT_END(AE), .CHARS(NC),
    .FIELD_LINES(FL), .VS_LINES(VS), .VACT_FIRST(VF), .VACT_LAST(VL)
  ) u_txt_raster_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .even_off(even_off), .lfb(lfb),
    .ffb(ffb), .tsync(tsync), .hact(hact), .vact(vact), .chr_stb(chr_stb),
    .chr_col(chr_col), .odd_even(odd_even)
  );

  always #5 clk = ~clk;

  // compare all outputs with the values required at a given position
  task automatic expect_at(string tag, int h, int ln, int f);
    logic e_ts, e_ha, e_va, e_st, e_oe;
    int   e_col, t;
    e_ts  = (ln < VS) ? (h < HALF - SE) : (h < SE);
    e_ha  = (h >= AS) && (h < AE);
    e_va  = (ln >= VF) && (ln <= VL);
    t     = h - AS;
    e_st  = e_ha && e_va && (((t * NC) % W) < NC);
    e_col = (e_ha && e_va) ? (t * NC) / W : 0;
    e_oe  = (f != 0) && !even_off;
    n_chk++;
    if (tsync !== e_ts || hact !== e_ha || vact !== e_va || chr_stb !== e_st ||
        chr_col !== 6'(e_col) || odd_even !== e_oe) begin
      n_bad++;
      $display("FAIL %s h=%0d line=%0d: ts/ha/va/st/col/oe got %b%b%b%b/%0d/%b exp %b%b%b%b/%0d/%b",
               tag, h, ln, tsync, hact, vact, chr_stb, chr_col, odd_even,
               e_ts, e_ha, e_va, e_st, e_col, e_oe);
    end
  endtask

  // closed-form position n clocks after reset release
  task automatic pos_of(int m, int n, output int h, output int ln, output int f);
    int len0, len1, off1, p, q;
    case (m)
      0:       begin len0 = FL*LC + HALF; len1 = FL*LC + HALF; off1 = HALF; end
      1:       begin len0 = FL*LC;        len1 = (FL+1)*LC;    off1 = 0;    end
      default: begin len0 = FL*LC;        len1 = FL*LC;        off1 = 0;    end
    endcase
    p = n % (len0 + len1);
    if (p < len0) begin f = 0; q = p; end
    else          begin f = 1; q = p - len0 + off1; end
    ln = q / LC;
    h  = q % LC;
  endtask

  task automatic do_reset(logic [1:0] m);
    mode = m; lfb = 1'b0; ffb = 1'b0; even_off = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    expect_at("R1", 0, 0, 0);
  endtask

  task automatic t_mode(logic [1:0] m, string tag, int cycles);
    int h, ln, f;
    do_reset(m);
    for (int n = 0; n < cycles; n++) begin
      pos_of(int'(m), n, h, ln, f);
      expect_at(tag, h, ln, f);
      @(negedge clk);
    end
  endtask

  task automatic t_parity_force();
    do_reset(2'b00);
    repeat (FL*LC + HALF + 10) @(negedge clk);
    expect_at("R10", HALF + 10, 0, 1);
    even_off = 1'b1;
    #1;
    expect_at("R10", HALF + 10, 0, 1);
    repeat (5) @(negedge clk);
    expect_at("R10", HALF + 15, 0, 1);
    even_off = 1'b0;
    #1;
    expect_at("R10", HALF + 15, 0, 1);
  endtask

  task automatic t_external();
    do_reset(2'b11);
    repeat (4*LC + 500) @(negedge clk);
    expect_at("R11", 500, 4, 0);
    lfb = 1'b1;
    @(negedge clk);
    lfb = 1'b0;
    for (int k = 0; k < LC; k++) begin
      expect_at("R11", k, 5, 0);
      @(negedge clk);
    end
    expect_at("R11", 0, 6, 0);
    ffb = 1'b1;
    @(negedge clk);
    ffb = 1'b0;
    for (int k = 0; k < 400; k++) begin
      expect_at("R12", 1 + k, 0, 1);
      @(negedge clk);
    end
    repeat (14*LC) @(negedge clk);
    expect_at("R12", 401, FL, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog expired got running exp finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mode(2'b00, "R2/R3/R4/R5/R6/R7/R10", (2*FL + 1)*LC + 2*LC);
    t_mode(2'b01, "R8", (2*FL + 1)*LC + 2*LC);
    t_mode(2'b10, "R9", 2*FL*LC + 2*LC);
    t_parity_force();
    t_external();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule